// File: doc/BRIEF.md
# Double-Buffered Parallel-In Serial-Out Register

This block takes a 16-bit snapshot of a set of parallel status lines and sends it out one bit at a time. It holds two copies of the data. The first copy is a holding latch. It is written only when the capture strobe goes from low to high. The second copy is the shift path, built from two 8-bit stages in series. Because the two copies are separate, a new snapshot can be taken while an earlier word is still going out, and the next word can follow the current one with no gap.

The control inputs `cap_stb`, `sh_clk` and `load_n` are sampled on the core clock `clk`, and the block acts on the edges and levels it sees there.

- **Loading:** while `load_n` is low, the shift path copies the holding latch on every core cycle.
- **Shifting:** while `load_n` is high, each rising edge of `sh_clk` moves the word one place toward the output. The bit at the top leaves first, and the bit freed at the bottom takes the value on `ser_in`. This lets several units be chained.
- **Output enable:** the serial output floats while `oe_n` is high.
- **Undriven inputs:** a parallel line whose drive flag is clear reads as 1. This stands in for a pull-up resistor.

Top module: `piso_dbuf`

## Requirements
- R1: After reset, both the holding latch and the shift path hold all ones. With `oe_n` low, `ser_out` is 1 and a 16-bit readout returns 0xFFFF.
- R2: A rising edge of `cap_stb` copies all 16 effective parallel inputs into the holding latch in one cycle. While `cap_stb` stays high, and while it is low, changes on `par_in` do not reach the latch.
- R3: A capture leaves the shift path untouched. A word that is part-way out finishes with its original bits.
- R4: While `load_n` is low, the shift path copies the holding latch on every core cycle, and `sh_clk` edges have no effect.
- R5: While `load_n` is high, each rising edge of `sh_clk` shifts the word toward bit 15. `ser_out` shows bit 15 first, then bit 14, and so on down to bit 0.
- R6: On each shift, bit 0 takes the value of `ser_in`. The bit driven on the first of 16 shifts ends up in bit 15.
- R7: The two 8-bit stages form one 16-bit path. Bit 7 of the lower stage moves into bit 8 of the upper stage on a shift.
- R8: While `oe_n` is high, `ser_out` is high impedance. Shifting still goes on while the output is off.
- R9: A parallel input whose `par_drv` bit is 0 is captured as 1, whatever value `par_in` has.
- R10: With `load_n` high, only a rising edge of `sh_clk` changes the shift path. A falling edge, or a steady level, leaves it as it is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock that samples all controls |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_stb | input | 1 | Capture strobe; a rising edge snapshots the parallel inputs |
| sh_clk | input | 1 | Shift clock; a rising edge shifts when in shift mode |
| load_n | input | 1 | Mode control: low loads from the latch, high shifts |
| oe_n | input | 1 | Active-low serial output enable |
| ser_in | input | 1 | Serial input for chaining units |
| par_in | input | 16 | Parallel status inputs |
| par_drv | input | 16 | Per-line drive flags; 0 means the line floats and reads 1 |
| ser_out | output | 1 | Tri-state serial output, top bit first |

## Verification
The bench goes after the following corner cases:

- **Capture in mid-word:** a capture is made half way through a word. A design that lets the capture reach the shift path would send out a mixed word.
- **Strobe held high:** `cap_stb` is held high while the inputs change. A level-sensitive latch would send the later value instead of the one present at the edge.
- **Shift clock during load:** `sh_clk` is toggled while `load_n` is low. A design that shifted in this mode would drop bits.
- **Stage boundary:** walking-one patterns cross bit 7. A broken link between the stages would lose the bit or swap the halves.
- **Output off:** shifts are made while the output is off. A design that gated shifting on the enable would show the bits late once the output is back on.
- **Floating lines:** mixed drive masks are used. A missing default would turn the floating lines into zeros.

// File: rtl/piso_dbuf.sv
module piso_dbuf #(
  parameter int STG_W  = 8,
  parameter int STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cap_stb,
  input  logic                      sh_clk,
  input  logic                      load_n,
  input  logic                      oe_n,
  input  logic                      ser_in,
  input  logic [STG_W*STAGES-1:0]   par_in,
  input  logic [STG_W*STAGES-1:0]   par_drv,
  output logic                      ser_out
);
  localparam int W = STG_W * STAGES;

  logic         cap_q, sck_q;
  logic [W-1:0] hold;
  logic [W-1:0] sr;
  logic [STAGES-1:0] link;

  wire cap_rise = cap_stb & ~cap_q;
  wire sck_rise = sh_clk & ~sck_q;
  wire [W-1:0] eff_in = par_in | ~par_drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= 1'b0;
      sck_q <= 1'b0;
    end else begin
      cap_q <= cap_stb;
      sck_q <= sh_clk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold <= '1;
    else if (cap_rise) hold <= eff_in;
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [STG_W-1:0] bits;
    if (g == 0) begin : g_head
      assign link[g] = ser_in;
    end else begin : g_chain
      assign link[g] = sr[g*STG_W-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        bits <= '1;
      else if (!load_n)  bits <= hold[g*STG_W +: STG_W];
      else if (sck_rise) bits <= {bits[STG_W-2:0], link[g]};
    end
    assign sr[g*STG_W +: STG_W] = bits;
  end

  assign ser_out = oe_n ? 1'bz : sr[W-1];

  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> sr == $past(hold)); // R4

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && sck_rise) |=> sr == {$past(sr[W-2:0]), $past(ser_in)}); // R5

  AST_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && !sck_rise) |=> $stable(sr)); // R10

  AST_CAP_SPARES_SR: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_rise && load_n && !sck_rise) |=> $stable(sr)); // R3

  AST_LATCH_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_rise |=> $stable(hold)); // R2

  AST_STAGE_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && sck_rise) |=> sr[STG_W] == $past(sr[STG_W-1])); // R7
endmodule

// File: tb/piso_dbuf_test.sv
module piso_dbuf_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cap_stb = 1'b0, sh_clk = 1'b0, load_n = 1'b1, oe_n = 1'b0, ser_in = 1'b1;
  logic [15:0] par_in = '0, par_drv = '1;
  wire ser_out;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  piso_dbuf uut (.clk(clk), .rst_n(rst_n), .cap_stb(cap_stb), .sh_clk(sh_clk),
    .load_n(load_n), .oe_n(oe_n), .ser_in(ser_in), .par_in(par_in),
    .par_drv(par_drv), .ser_out(ser_out));

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic capture(input logic [15:0] v);
    @(negedge clk); par_in = v; cap_stb = 1'b1;
    @(negedge clk); cap_stb = 1'b0;
  endtask

  task automatic do_load();
    @(negedge clk); load_n = 1'b0;
    @(negedge clk); load_n = 1'b1;
  endtask

  task automatic shift_bits(input int n, input logic [15:0] fill, input int first,
                            inout logic [15:0] got);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      got[15-(first+k)] = ser_out;
      ser_in = fill[15-(first+k)];
      sh_clk = 1'b1;
      @(negedge clk); sh_clk = 1'b0;
    end
  endtask

  task automatic read_word(input logic [15:0] fill, output logic [15:0] got);
    logic [15:0] g = '0;
    shift_bits(16, fill, 0, g);
    got = g;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] w, v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ser_out", {15'd0, ser_out}, 16'h0001);
    read_word(16'hFFFF, w);
    chk("R1 reset word", w, 16'hFFFF);

    for (int i = 0; i < 16; i++) begin
      v = 16'h1 << i;
      capture(v); do_load(); read_word(16'h0000, w);
      chk("R5 R7 walking one", w, v);
      capture(~v); do_load(); read_word(16'hFFFF, w);
      chk("R5 R7 walking zero", w, ~v);
    end

    for (int i = 0; i < 24; i++) begin
      v = 16'(i * 16'h9E37 + 16'h1234);
      capture(v); do_load(); read_word(~v, w);
      chk("R5 arith pattern", w, v);
      read_word(16'h0000, w);
      chk("R6 serial fill", w, ~v);
    end

    capture(16'hA5C3); do_load();
    w = '0;
    shift_bits(8, 16'h0000, 0, w);
    capture(16'h3C69);
    shift_bits(8, 16'h0000, 8, w);
    chk("R3 midword capture keeps word", w, 16'hA5C3);
    do_load(); read_word(16'h0000, w);
    chk("R3 next word gapless", w, 16'h3C69);

    @(negedge clk); par_in = 16'h1111; cap_stb = 1'b1;
    @(negedge clk); par_in = 16'h2222;
    @(negedge clk); par_in = 16'h4444;
    @(negedge clk); cap_stb = 1'b0; par_in = 16'h8888;
    do_load(); read_word(16'h0000, w);
    chk("R2 edge not level", w, 16'h1111);

    capture(16'h8001);
    @(negedge clk); load_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); sh_clk = ~sh_clk;
    end
    @(negedge clk); sh_clk = 1'b0;
    @(negedge clk); load_n = 1'b1;
    read_word(16'h0000, w);
    chk("R4 shift ignored in load", w, 16'h8001);

    capture(16'h4000); do_load();
    @(negedge clk); sh_clk = 1'b1;
    repeat (3) @(negedge clk);
    sh_clk = 1'b0;
    repeat (3) @(negedge clk);
    read_word(16'h0000, w);
    chk("R10 one shift per rising edge", w, 16'h8000);

    capture(16'hF0F0); do_load();
    @(negedge clk); oe_n = 1'b1;
    @(negedge clk);
    chk("R8 hi-z", {15'd0, (ser_out === 1'bz)}, 16'h0001);
    w = '0;
    shift_bits(4, 16'h0000, 0, w);
    @(negedge clk); oe_n = 1'b0;
    shift_bits(12, 16'h0000, 4, w);
    chk("R8 shifting continues while off", w[11:0], 16'h00F0);

    for (int i = 0; i < 8; i++) begin
      v = 16'(i * 16'h3A5B + 16'h0F0F);
      @(negedge clk); par_drv = v;
      capture(16'h0000); do_load(); read_word(16'h0000, w);
      chk("R9 undriven reads one", w, ~v);
    end
    par_drv = '1;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule